// File: doc/BRIEF.md
# I2C Bit-Level Master Engine with Bus Recovery

This block sits under a transaction controller and moves one I2C bus primitive at a time. Each command is one of six: a bus-recovery burst, a START condition, a STOP condition, a byte write with acknowledge capture, a byte read that returns an acknowledge level chosen by the caller, or a reserved code that does nothing. The engine only ever pulls SCL or SDA low, through two output-enable signals, and it observes the bus through the SDA input. The caller sequences whole transfers (address, register index, data) by issuing these commands back to back.

All bus timing is built from a quarter-bit time unit. This unit is the programmable divider value in system clocks, and a divider of zero counts as one clock. Every primitive is a fixed list of time units, and at the start of each unit the engine may pull down or release either line. The controller therefore gets the same bus waveform at any divider setting, scaled in time. Write and read results come back with a one-cycle completion pulse.

Top module: `i2c_bit_engine`

## Requirements
- R1: While and after reset, scl_oe and sda_oe are 0 (both lines released), busy and done are 0, cmd_ready is 1, and rx_byte and ack_seen are 0.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both 1. cmd_ready equals the inverse of busy. busy is 1 from that edge for exactly N×U clocks, where U is the unit length and N is the command's unit count: 40 for recovery, 4 for START, 4 for STOP, 37 for write, 29 for read and 1 for a reserved code. done is then 1 for one clock with busy at 0. Between commands the line enables do not change.
- R3: The unit length U equals div_val in clocks, or 1 when div_val is 0. It is captured when the command is taken.
- R4: START is code 1 and runs 4 units. Unit 0 keeps both lines. Unit 1 releases SDA. Unit 2 releases SCL. Unit 3 pulls SDA low while SCL stays released.
- R5: STOP is code 2 and runs 4 units. It pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA, so it ends with both lines released.
- R6: Write is code 3 and sends cmd_txbyte most significant bit first in 4 units per bit. SCL is pulled low, one unit later SDA takes the bit (a 1 releases it), then SCL is released for two units. SDA never changes while SCL is released.
- R7: After the eighth bit of a write, SDA is released and a ninth clock of the same shape is issued. SDA is sampled at the end of its second high unit, and ack_seen gets that level (1 is NACK, 0 is ACK). One final unit then pulls SCL low. Every command other than write leaves ack_seen at 0.
- R8: Read is code 4 and releases SDA. It clocks eight bits in 3 units each: SCL low, SCL released with SDA sampled at the end of that unit, then one more high unit. The bits shift into rx_byte most significant first. Only a read changes rx_byte.
- R9: After the eighth read bit, the engine pulls SCL low. One unit later it drives cmd_ackbit on SDA (0 pulls low for ACK, 1 releases for NACK). It then releases SCL for two units and pulls SCL low for one final unit.
- R10: Recovery is code 0. SDA is released and SCL gets nine pulses, each 2 units low and then 2 units released. A 4-unit STOP follows and leaves both lines released.
- R11: While busy is 1, cmd_valid, cmd_code and the other command inputs have no effect on the lines, the timing or the results.
- R12: Codes 5, 6 and 7 are taken, leave both lines unchanged, and complete after a single unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Quarter-bit unit length in clocks (0 acts as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_code | input | 3 | 0 recovery, 1 START, 2 STOP, 3 write, 4 read |
| cmd_txbyte | input | 8 | Byte to send on a write |
| cmd_ackbit | input | 1 | Acknowledge level to send after a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| rx_byte | output | 8 | Byte received by the last read |
| ack_seen | output | 1 | SDA level sampled in the write acknowledge slot |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The recovery, START, write, read and STOP commands are run at divider settings 0, 1, 2 and 3. Comparing each setting shows whether every unit stretches uniformly and whether zero really maps to one clock. Write bytes A5, 00, FF and 5A separate the bit order from the line polarity, and they are paired with a slave that either pulls down or stays released in the acknowledge slot. Read bytes 3C, C3 and 81 are returned with both acknowledge levels, so a swapped shift direction, a wrong sample unit or an inverted acknowledge drive each give a different bus pattern. A reserved code and a burst of foreign commands during a busy write show that nothing leaks into the sequence.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  localparam int unsigned BITS       = 8;
  localparam int unsigned REC_PULSES = 9;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned REC_SLOTS  = REC_PULSES * 4;
  localparam int unsigned WR_SLOTS   = (BITS + 1) * 4;
  localparam int unsigned RD_SLOTS   = BITS * 3;

  localparam logic [2:0] OP_RECOVER = 3'd0;
  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_WRITE   = 3'd3;
  localparam logic [2:0] OP_READ    = 3'd4;

  typedef enum logic [1:0] {
    LN_KEEP = 2'd0,
    LN_LOW  = 2'd1,
    LN_REL  = 2'd2
  } line_act_e;

  typedef struct packed {
    line_act_e scl;
    line_act_e sda;
    logic      smp_bit;
    logic      smp_ack;
    logic      last;
  } slot_t;

  localparam slot_t SLOT_IDLE = '{scl: LN_KEEP, sda: LN_KEEP,
                                  smp_bit: 1'b0, smp_ack: 1'b0, last: 1'b0};

  // Four-unit stop condition, shared by STOP and the tail of recovery.
  function automatic slot_t stop_slot(input logic [1:0] ph);
    slot_t s;
    s = SLOT_IDLE;
    case (ph)
      2'd0:    s.scl = LN_LOW;
      2'd1:    s.sda = LN_LOW;
      2'd2:    s.scl = LN_REL;
      default: begin
        s.sda  = LN_REL;
        s.last = 1'b1;
      end
    endcase
    return s;
  endfunction

  // Line actions and sample strobes for unit idx of command op.
  function automatic slot_t slot_decode(input logic [2:0]       op,
                                        input logic [IDX_W-1:0] idx,
                                        input logic [BITS-1:0]  txb,
                                        input logic             ackb);
    slot_t            s;
    logic [IDX_W-1:0] rel;
    logic [IDX_W-1:0] ph3;
    logic [IDX_W-3:0] bitn;
    logic [BITS-1:0]  sh;
    s    = SLOT_IDLE;
    rel  = '0;
    ph3  = '0;
    bitn = idx[IDX_W-1:2];
    sh   = txb << bitn;
    case (op)
      OP_RECOVER: begin
        if (idx < IDX_W'(REC_SLOTS)) begin
          s.sda = LN_REL;
          s.scl = idx[1] ? LN_REL : LN_LOW;
        end else begin
          rel = idx - IDX_W'(REC_SLOTS);
          s   = stop_slot(rel[1:0]);
        end
      end
      OP_START: begin
        case (idx[1:0])
          2'd1: s.sda = LN_REL;
          2'd2: s.scl = LN_REL;
          2'd3: begin
            s.sda  = LN_LOW;
            s.last = 1'b1;
          end
          default: ;
        endcase
      end
      OP_STOP: s = stop_slot(idx[1:0]);
      OP_WRITE: begin
        if (idx == IDX_W'(WR_SLOTS)) begin
          s.scl  = LN_LOW;
          s.last = 1'b1;
        end else begin
          case (idx[1:0])
            2'd0: s.scl = LN_LOW;
            2'd1: s.sda = (bitn < (IDX_W-2)'(BITS) && !sh[BITS-1]) ? LN_LOW : LN_REL;
            2'd2: s.scl = LN_REL;
            default: s.smp_ack = (bitn == (IDX_W-2)'(BITS));
          endcase
        end
      end
      OP_READ: begin
        if (idx < IDX_W'(RD_SLOTS)) begin
          ph3 = idx % IDX_W'(3);
          case (ph3)
            IDX_W'(0): begin
              s.scl = LN_LOW;
              s.sda = LN_REL;
            end
            IDX_W'(1): begin
              s.scl     = LN_REL;
              s.smp_bit = 1'b1;
            end
            default: ;
          endcase
        end else begin
          rel = idx - IDX_W'(RD_SLOTS);
          case (rel[2:0])
            3'd0: s.scl = LN_LOW;
            3'd1: s.sda = ackb ? LN_REL : LN_LOW;
            3'd2: s.scl = LN_REL;
            3'd4: begin
              s.scl  = LN_LOW;
              s.last = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: s.last = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/i2cbe_tick.sv
module i2cbe_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] span;
  logic [DIV_W-1:0] reload_q;
  logic [DIV_W-1:0] cnt_q;

  // A zero divider behaves as one clock per unit.
  assign span = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      reload_q <= span;
      cnt_q    <= span;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - DIV_W'(1);
    end
  end

endmodule

// File: rtl/i2cbe_lines.sv
module i2cbe_lines
  import i2cbe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  apply,
  input  slot_t act,
  output logic  scl_oe,
  output logic  sda_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (apply) begin
      case (act.scl)
        LN_LOW:  scl_oe <= 1'b1;
        LN_REL:  scl_oe <= 1'b0;
        default: ;
      endcase
      case (act.sda)
        LN_LOW:  sda_oe <= 1'b1;
        LN_REL:  sda_oe <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cbe_capture.sv
module i2cbe_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_ack,
  input  logic         smp_bit,
  input  logic         smp_ack,
  input  logic         sda_in,
  output logic [W-1:0] rx_byte,
  output logic         ack_seen
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte  <= '0;
      ack_seen <= 1'b0;
    end else begin
      if (smp_bit) rx_byte <= {rx_byte[W-2:0], sda_in};
      if (clr_ack)      ack_seen <= 1'b0;
      else if (smp_ack) ack_seen <= sda_in;
    end
  end

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cbe_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_code,
  input  logic [BITS-1:0]  cmd_txbyte,
  input  logic             cmd_ackbit,
  output logic             busy,
  output logic             done,
  output logic [BITS-1:0]  rx_byte,
  output logic             ack_seen,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);

  logic             busy_q;
  logic             done_q;
  logic [2:0]       cmd_q;
  logic [BITS-1:0]  tx_q;
  logic             ackb_q;
  logic [IDX_W-1:0] idx_q;

  logic  accept;
  logic  tick;
  logic  apply;
  slot_t cur;
  slot_t first;
  slot_t nxt;
  slot_t act;

  assign accept    = cmd_valid && !busy_q;
  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;

  always_comb begin
    cur   = slot_decode(cmd_q, idx_q, tx_q, ackb_q);
    nxt   = slot_decode(cmd_q, idx_q + IDX_W'(1), tx_q, ackb_q);
    first = slot_decode(cmd_code, '0, cmd_txbyte, cmd_ackbit);
    act   = accept ? first : nxt;
    apply = accept || (tick && !cur.last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cmd_q  <= '0;
      tx_q   <= '0;
      ackb_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_code;
        tx_q   <= cmd_txbyte;
        ackb_q <= cmd_ackbit;
        idx_q  <= '0;
      end else if (tick) begin
        if (cur.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  i2cbe_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .run  (busy_q),
    .div  (div_val),
    .tick (tick)
  );

  i2cbe_lines u_lines (
    .clk    (clk),
    .rst    (rst),
    .apply  (apply),
    .act    (act),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
  );

  i2cbe_capture #(.W(BITS)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clr_ack  (accept),
    .smp_bit  (tick && cur.smp_bit),
    .smp_ack  (tick && cur.smp_ack),
    .sda_in   (sda_in),
    .rx_byte  (rx_byte),
    .ack_seen (ack_seen)
  );

endmodule

// File: rtl/i2cbe_checker.sv
module i2cbe_checker
  import i2cbe_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] cur_op
);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> busy);

  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> ($stable(scl_oe) && $stable(sda_oe)));

  // SDA moves only while SCL is held low during a byte write.
  p_wr_sda_low_phase_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && cur_op == OP_WRITE && !$stable(sda_oe))
      |-> (scl_oe && $past(scl_oe)));

  // SDA stays put while SCL is released during a byte read.
  p_rd_sda_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && cur_op == OP_READ && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe));

endmodule

bind i2c_bit_engine i2cbe_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .cur_op    (cmd_q)
);

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;

  localparam int DIV_W = 16;
  localparam int REL = 0;
  localparam int LOW = 1;
  localparam int KP  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_val = '0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [2:0]       cmd_code = '0;
  logic [7:0]       cmd_txbyte = '0;
  logic             cmd_ackbit = 1'b0;
  logic             busy;
  logic             done;
  logic [7:0]       rx_byte;
  logic             ack_seen;
  logic             scl_oe;
  logic             sda_oe;
  logic             sda_in = 1'b1;

  always #4 clk = ~clk;

  i2c_bit_engine #(.DIV_W(DIV_W)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .div_val    (div_val),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_code   (cmd_code),
    .cmd_txbyte (cmd_txbyte),
    .cmd_ackbit (cmd_ackbit),
    .busy       (busy),
    .done       (done),
    .rx_byte    (rx_byte),
    .ack_seen   (ack_seen),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .sda_in     (sda_in)
  );

  typedef struct packed {
    bit scl;
    bit sda;
    bit bsy;
    bit dn;
    bit slv;
  } ent_t;

  ent_t     q[$];
  bit       m_scl = 1'b0;
  bit       m_sda = 1'b0;
  int       dly = 1;
  int       total = 0;
  int       bad = 0;
  bit [7:0] last_rx = 8'h00;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One time unit: 0 release, 1 pull low, 2 keep; slv = slave pulls SDA.
  task automatic unit(input int s, input int d, input bit slv);
    if (s != KP) m_scl = (s == LOW);
    if (d != KP) m_sda = (d == LOW);
    for (int i = 0; i < dly; i++)
      q.push_back('{scl: m_scl, sda: m_sda, bsy: 1'b1, dn: 1'b0, slv: slv});
  endtask

  task automatic m_stop();
    unit(LOW, KP, 0); unit(KP, LOW, 0); unit(REL, KP, 0); unit(KP, REL, 0);
  endtask

  task automatic m_start();
    unit(KP, KP, 0); unit(KP, REL, 0); unit(REL, KP, 0); unit(KP, LOW, 0);
  endtask

  task automatic m_recover();
    for (int p = 0; p < 9; p++) begin
      unit(LOW, REL, 0); unit(KP, KP, 0); unit(REL, KP, 0); unit(KP, KP, 0);
    end
    m_stop();
  endtask

  task automatic m_write(input bit [7:0] data, input bit slave_ack);
    for (int b = 7; b >= 0; b--) begin
      unit(LOW, KP, 0); unit(KP, data[b] ? REL : LOW, 0);
      unit(REL, KP, 0); unit(KP, KP, 0);
    end
    unit(LOW, KP, 0); unit(KP, REL, slave_ack);
    unit(REL, KP, slave_ack); unit(KP, KP, slave_ack);
    unit(LOW, KP, 0);
  endtask

  task automatic m_read(input bit [7:0] data, input bit ab);
    for (int b = 7; b >= 0; b--) begin
      unit(LOW, REL, !data[b]); unit(REL, KP, !data[b]); unit(KP, KP, !data[b]);
    end
    unit(LOW, KP, 0); unit(KP, ab ? REL : LOW, 0);
    unit(REL, KP, 0); unit(KP, KP, 0); unit(LOW, KP, 0);
  endtask

  task automatic run(input bit [2:0] code, input bit [7:0] tx, input bit ab,
                     input int div, input bit slave_ack, input bit [7:0] sdata,
                     input string tag, input bit intrude);
    bit exp_ack;
    int n;
    ent_t e;
    exp_ack = 1'b0;
    dly = (div == 0) ? 1 : div;
    @(negedge clk);
    chk(scl_oe == m_scl && sda_oe == m_sda, "R2", "idle lines",
        {scl_oe, sda_oe}, {m_scl, m_sda});
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R2", "ready when idle",
        {cmd_ready, busy}, 2'b10);
    div_val    = DIV_W'(div);
    cmd_code   = code;
    cmd_txbyte = tx;
    cmd_ackbit = ab;
    cmd_valid  = 1'b1;
    case (code)
      3'd0: m_recover();
      3'd1: m_start();
      3'd2: m_stop();
      3'd3: begin m_write(tx, slave_ack); exp_ack = !slave_ack; end
      3'd4: m_read(sdata, ab);
      default: unit(KP, KP, 0);
    endcase
    q.push_back('{scl: m_scl, sda: m_sda, bsy: 1'b0, dn: 1'b1, slv: 1'b0});
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      chk(scl_oe == e.scl && sda_oe == e.sda, tag, $sformatf("lines cycle %0d", n),
          {scl_oe, sda_oe}, {e.scl, e.sda});
      chk(busy == e.bsy && done == e.dn && cmd_ready == !e.bsy, "R2",
          $sformatf("busy/done/ready cycle %0d", n),
          {busy, done, cmd_ready}, {e.bsy, e.dn, !e.bsy});
      if (e.dn) begin
        chk(ack_seen == exp_ack, "R7", "ack_seen at done", ack_seen, exp_ack);
        if (code == 3'd4) last_rx = sdata;
        chk(rx_byte == last_rx, "R8", "rx_byte at done", rx_byte, last_rx);
      end
      if (intrude) begin
        // R11: foreign command presented while busy
        if (n == 1) begin
          cmd_valid  = 1'b1;
          cmd_code   = 3'd2;
          cmd_txbyte = 8'h00;
          div_val    = DIV_W'(7);
        end
        if (n == 3) cmd_valid = 1'b0;
      end
      sda_in = !(sda_oe || e.slv);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0 && done == 0 && cmd_ready == 1,
        "R1", "outputs in reset", {scl_oe, sda_oe, busy, done, cmd_ready}, 5'b00001);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_byte == 8'h00 && ack_seen == 1'b0, "R1", "results after reset",
        {rx_byte, ack_seen}, 9'h000);
    chk(scl_oe == 0 && sda_oe == 0, "R1", "lines after reset",
        {scl_oe, sda_oe}, 2'b00);

    // divider 0 acts as 1 clock per unit
    run(3'd0, 8'h00, 1'b0, 0, 1'b0, 8'h00, "R10/R3", 1'b0);
    run(3'd1, 8'h00, 1'b0, 0, 1'b0, 8'h00, "R4/R3", 1'b0);
    run(3'd3, 8'hA5, 1'b0, 0, 1'b1, 8'h00, "R6/R7", 1'b0);
    run(3'd4, 8'h00, 1'b0, 0, 1'b0, 8'h3C, "R8/R9", 1'b0);
    run(3'd4, 8'h00, 1'b1, 0, 1'b0, 8'hC3, "R8/R9", 1'b0);
    run(3'd2, 8'h00, 1'b0, 0, 1'b0, 8'h00, "R5/R3", 1'b0);

    // divider 3
    run(3'd1, 8'h00, 1'b0, 3, 1'b0, 8'h00, "R4/R3", 1'b0);
    run(3'd3, 8'h00, 1'b0, 3, 1'b0, 8'h00, "R6/R7/R3", 1'b0);
    run(3'd3, 8'hFF, 1'b0, 3, 1'b1, 8'h00, "R6/R7/R3", 1'b0);
    run(3'd4, 8'h00, 1'b1, 3, 1'b0, 8'h81, "R8/R9/R3", 1'b0);
    run(3'd2, 8'h00, 1'b0, 3, 1'b0, 8'h00, "R5/R3", 1'b0);

    // divider 2: reserved code, busy intrusion, recovery
    run(3'd6, 8'h00, 1'b0, 2, 1'b0, 8'h00, "R12", 1'b0);
    run(3'd1, 8'h00, 1'b0, 2, 1'b0, 8'h00, "R4/R3", 1'b0);
    run(3'd3, 8'h5A, 1'b0, 2, 1'b1, 8'h00, "R11/R6", 1'b1);
    run(3'd7, 8'h00, 1'b0, 2, 1'b0, 8'h00, "R12", 1'b0);
    run(3'd0, 8'h00, 1'b0, 2, 1'b0, 8'h00, "R10/R3", 1'b0);

    // divider 1
    run(3'd1, 8'h00, 1'b0, 1, 1'b0, 8'h00, "R4/R3", 1'b0);
    run(3'd2, 8'h00, 1'b0, 1, 1'b0, 8'h00, "R5/R3", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule